// File: doc/BRIEF.md
# Four-Layer Overlay Compositor

The compositor builds one 4:2:2 YCbCr output pixel per raster position. It stacks two video layers and two bitmap overlay layers. For each of the four windows it decides whether the current raster coordinate falls inside that window. It then turns the coordinate into a window-relative pixel request, taking account of the horizontal and vertical zoom factor and, for interlaced windows, the field parity. The memory side answers the request in the same cycle with the pixel data for each window.

The video layers are chosen by priority. The first overlay is then blended on top in eight weight steps, and the second overlay after it. A zero overlay pixel lets the layers beneath show through unchanged. The second overlay can instead act as an attribute plane for the first: it supplies the blend weight and a blink flag, and a frame-counted blink timer hides flagged pixels during the off phase.

The result is registered. It appears with a valid flag one clock after the raster position is presented.

Top module: `osd_compositor`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid and out_pix are cleared to zero.
- R2: out_valid equals pix_valid of the previous cycle; out_pix takes the composed pixel one cycle after a cycle with pix_valid high and holds its value after a cycle with pix_valid low.
- R3: Window i hits (req_hit[i] high) only when win_en[i] is set, raster_x >= start x and (raster_x - start x) < width << zoom shift, and the same test passes vertically against height; otherwise req_hit[i] is low.
- R4: Zoom code 0, 1, 2 selects shift 0, 1, 2 (factor 1, 2, 4); code 3 acts like code 2. The request coordinate is the window-relative coordinate shifted right by that amount, separately for x and y.
- R5: With win_field[i] set, window i hits only on lines whose raster_y bit 0 equals field_id, and its vertical relative coordinate is (raster_y - start y) >> 1 before zoom; the height test uses that halved coordinate.
- R6: Layer order from back to front is bg_pix, video 0, video 1, overlay 0, overlay 1; a covering higher video layer replaces a lower one, and where nothing covers the pixel the output is bg_pix.
- R7: An overlay pixel with weight k (3-bit field, ovl_level[2:0] for overlay 0, ovl_level[5:3] for overlay 1) combines with the layer below as (ovl*k + below*(8-k)) >> 3, separately for the Y byte [15:8] and the chroma byte [7:0].
- R8: An overlay pixel whose 16-bit value is zero is transparent: the layer beneath passes through unchanged.
- R9: With attr_mode set, overlay 1 is not drawn. Where overlay 1 hits, bits [2:0] of its pixel replace overlay 0's weight and bit 3 marks the pixel as blinking.
- R10: The blink phase starts visible at reset and toggles on every (blink_reload+1)-th vsync pulse. During the hidden phase, a blinking-marked overlay 0 pixel is treated as transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Raster position is valid this cycle |
| raster_x | input | XW | Current horizontal raster position |
| raster_y | input | YW | Current vertical raster line (frame numbering) |
| field_id | input | 1 | Parity of the field being displayed |
| vsync | input | 1 | One-cycle frame strobe for the blink timer |
| win_en | input | 4 | Enable per window (0,1 video; 2,3 overlay) |
| win_field | input | 4 | Interlaced mode per window |
| win_x0 | input | 4*XW | Start x per window |
| win_y0 | input | 4*YW | Start y per window |
| win_w | input | 4*XW | Width per window in source pixels |
| win_h | input | 4*YW | Height per window in source lines |
| win_zoom_h | input | 8 | Horizontal zoom code per window |
| win_zoom_v | input | 8 | Vertical zoom code per window |
| ovl_level | input | 6 | Blend weight per overlay |
| attr_mode | input | 1 | Overlay 1 acts as attribute plane |
| blink_reload | input | BW | Blink phase length minus one, in frames |
| bg_pix | input | 2*CW | Background colour |
| req_hit | output | 4 | Window covers the raster position |
| req_x | output | 4*XW | Window-relative pixel column request |
| req_y | output | 4*YW | Window-relative pixel row request |
| win_pix | input | 4*2*CW | Pixel data returned per window |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 2*CW | Composed pixel, Y in the high byte |

## Verification
The bench builds the block with its default parameters: 11-bit coordinates, 8-bit components and an 8-bit blink reload. It places windows at small offsets, so every edge of a zoomed or field-mode window can be reached in a few probes. A reload of 2 makes the blink phase turn over after three vsync pulses, so both phases and the return to visible fit in a short run. The component width of 8 lets the blend arithmetic be checked at the weights 0, 3, 5 and 7.

// File: rtl/osd_pkg.sv
// Shared constants and helpers for the overlay compositor.
// Assumes window indices 0,1 are video layers and 2,3 are overlays.
package osd_pkg;
    localparam int NWIN    = 4;
    localparam int VID0    = 0;
    localparam int VID1    = 1;
    localparam int OVL0    = 2;
    localparam int OVL1    = 3;
    localparam int ZCODE_W = 2;
    localparam int LVL_W   = 3;

    // Map a 2-bit zoom code to a shift amount (code 3 behaves as code 2).
    function automatic logic [1:0] zoom_shift(input logic [ZCODE_W-1:0] code);
        case (code)
            2'd0:    zoom_shift = 2'd0;
            2'd1:    zoom_shift = 2'd1;
            default: zoom_shift = 2'd2;
        endcase
    endfunction
endpackage

// File: rtl/osd_win_map.sv
// Window mapper: decides whether the raster position lies inside one
// window and produces the window-relative pixel request.
// Assumes start coordinates, sizes and zoom codes are stable per frame.
module osd_win_map
    import osd_pkg::*;
#(
    parameter int XW = 11,
    parameter int YW = 11
) (
    input  logic               en,
    input  logic               field_mode,
    input  logic               field_id,
    input  logic [XW-1:0]      x,
    input  logic [YW-1:0]      y,
    input  logic [XW-1:0]      x0,
    input  logic [YW-1:0]      y0,
    input  logic [XW-1:0]      w,
    input  logic [YW-1:0]      h,
    input  logic [ZCODE_W-1:0] zh,
    input  logic [ZCODE_W-1:0] zv,
    output logic               hit,
    output logic [XW-1:0]      rx,
    output logic [YW-1:0]      ry
);
    localparam int XSW = XW + 2;
    localparam int YSW = YW + 2;

    logic [1:0]    sh_x, sh_y;
    logic [XSW-1:0] span_w;
    logic [YSW-1:0] span_h;
    logic [XW-1:0] dx;
    logic [YW-1:0] dy, row;
    logic          in_x, in_y, parity_ok;

    // Zoomed span of the window in raster units.
    always_comb begin
        sh_x   = zoom_shift(zh);
        sh_y   = zoom_shift(zv);
        span_w = {2'b00, w} << sh_x;
        span_h = {2'b00, h} << sh_y;
    end

    // Relative coordinates, field-line selection and hit test.
    always_comb begin
        dx        = x - x0;
        dy        = y - y0;
        row       = field_mode ? (dy >> 1) : dy;
        parity_ok = !field_mode || (y[0] == field_id);
        in_x      = (x >= x0) && ({2'b00, dx} < span_w);
        in_y      = (y >= y0) && parity_ok && ({2'b00, row} < span_h);
        hit       = en && in_x && in_y;
        rx        = dx >> sh_x;
        ry        = row >> sh_y;
    end
endmodule

// File: rtl/osd_blend.sv
// Eight-step blender: mixes an overlay pixel onto the pixel below with
// weight level/8, per byte. Passes the lower pixel through when apply is low.
// Assumes a pixel is two components of CW bits, Y in the upper half.
module osd_blend #(
    parameter int CW = 8
) (
    input  logic [2*CW-1:0] below,
    input  logic [2*CW-1:0] ovl,
    input  logic [2:0]      level,
    input  logic            apply,
    output logic [2*CW-1:0] mixed
);
    localparam int AW = CW + 4;

    logic [2*CW-1:0] blend_v;

    for (genvar c = 0; c < 2; c++) begin : g_comp
        logic [AW-1:0] acc;
        // Weighted sum of one component; total weight is always eight.
        always_comb begin
            acc = AW'(ovl[c*CW +: CW]) * AW'(level)
                + AW'(below[c*CW +: CW]) * (AW'(8) - AW'(level));
            blend_v[c*CW +: CW] = acc[CW+2:3];
        end
    end

    // Choose between blended and pass-through value.
    always_comb mixed = apply ? blend_v : below;
endmodule

// File: rtl/osd_blink.sv
// Blink timer: counts vsync strobes and flips the visible phase every
// reload+1 frames. Assumes vsync is a single-cycle strobe per frame.
module osd_blink #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync,
    input  logic [BW-1:0] reload,
    output logic          blink_on
);
    logic [BW-1:0] cnt;

    // Frame countdown and phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= reload;
            blink_on <= 1'b1;
        end else if (vsync) begin
            if (cnt == '0) begin
                cnt      <= reload;
                blink_on <= ~blink_on;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    p_phase_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(blink_on));
    p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && cnt == '0) |=> (cnt == $past(reload)));
endmodule

// File: rtl/osd_compositor.sv
// Four-layer compositor: maps the raster position into two video and two
// overlay windows, picks the top video layer, blends both overlays with
// transparency and attribute/blink control, and registers the result.
// Assumes win_pix answers req_x/req_y combinationally in the same cycle.
module osd_compositor
    import osd_pkg::*;
#(
    parameter int XW = 11,
    parameter int YW = 11,
    parameter int CW = 8,
    parameter int BW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_valid,
    input  logic [XW-1:0]           raster_x,
    input  logic [YW-1:0]           raster_y,
    input  logic                    field_id,
    input  logic                    vsync,
    input  logic [NWIN-1:0]         win_en,
    input  logic [NWIN-1:0]         win_field,
    input  logic [NWIN*XW-1:0]      win_x0,
    input  logic [NWIN*YW-1:0]      win_y0,
    input  logic [NWIN*XW-1:0]      win_w,
    input  logic [NWIN*YW-1:0]      win_h,
    input  logic [NWIN*ZCODE_W-1:0] win_zoom_h,
    input  logic [NWIN*ZCODE_W-1:0] win_zoom_v,
    input  logic [2*LVL_W-1:0]      ovl_level,
    input  logic                    attr_mode,
    input  logic [BW-1:0]           blink_reload,
    input  logic [2*CW-1:0]         bg_pix,
    output logic [NWIN-1:0]         req_hit,
    output logic [NWIN*XW-1:0]      req_x,
    output logic [NWIN*YW-1:0]      req_y,
    input  logic [NWIN*2*CW-1:0]    win_pix,
    output logic                    out_valid,
    output logic [2*CW-1:0]         out_pix
);
    localparam int PW = 2 * CW;

    logic [PW-1:0] wpix [NWIN];
    logic [PW-1:0] video_px, stage1_px, stage2_px;
    logic [LVL_W-1:0] lvl0;
    logic          blink_on, attr_hit, attr_hide, ovl0_vis, ovl1_vis;

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        osd_win_map #(.XW(XW), .YW(YW)) u_map (
            .en         (win_en[i]),
            .field_mode (win_field[i]),
            .field_id   (field_id),
            .x          (raster_x),
            .y          (raster_y),
            .x0         (win_x0[i*XW +: XW]),
            .y0         (win_y0[i*YW +: YW]),
            .w          (win_w[i*XW +: XW]),
            .h          (win_h[i*YW +: YW]),
            .zh         (win_zoom_h[i*ZCODE_W +: ZCODE_W]),
            .zv         (win_zoom_v[i*ZCODE_W +: ZCODE_W]),
            .hit        (req_hit[i]),
            .rx         (req_x[i*XW +: XW]),
            .ry         (req_y[i*YW +: YW])
        );
        assign wpix[i] = win_pix[i*PW +: PW];

        p_req_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
            req_hit[i] |-> (req_x[i*XW +: XW] < win_w[i*XW +: XW])
                        && (req_y[i*YW +: YW] < win_h[i*YW +: YW]));
        p_field_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_hit[i] && win_field[i]) |-> (raster_y[0] == field_id));
        p_disabled_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !win_en[i] |-> !req_hit[i]);
    end

    osd_blink #(.BW(BW)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsync    (vsync),
        .reload   (blink_reload),
        .blink_on (blink_on)
    );

    // Video layer priority over the background.
    always_comb begin
        video_px = bg_pix;
        if (req_hit[VID0]) video_px = wpix[VID0];
        if (req_hit[VID1]) video_px = wpix[VID1];
    end

    // Overlay visibility, attribute weight and blink masking.
    always_comb begin
        attr_hit  = attr_mode && req_hit[OVL1];
        attr_hide = attr_hit && wpix[OVL1][3] && !blink_on;
        lvl0      = attr_hit ? wpix[OVL1][2:0] : ovl_level[LVL_W-1:0];
        ovl0_vis  = req_hit[OVL0] && (wpix[OVL0] != '0) && !attr_hide;
        ovl1_vis  = !attr_mode && req_hit[OVL1] && (wpix[OVL1] != '0);
    end

    osd_blend #(.CW(CW)) u_blend_ovl0 (
        .below (video_px),
        .ovl   (wpix[OVL0]),
        .level (lvl0),
        .apply (ovl0_vis),
        .mixed (stage1_px)
    );

    osd_blend #(.CW(CW)) u_blend_ovl1 (
        .below (stage1_px),
        .ovl   (wpix[OVL1]),
        .level (ovl_level[2*LVL_W-1:LVL_W]),
        .apply (ovl1_vis),
        .mixed (stage2_px)
    );

    // Output register with valid flag; pixel holds when no valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= pix_valid;
            if (pix_valid) out_pix <= stage2_px;
        end
    end

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (!out_valid && $stable(out_pix)));
    p_bg_when_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && req_hit == '0) |=> (out_pix == $past(bg_pix)));
    p_transparent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && req_hit == 4'b0100 && wpix[OVL0] == '0)
            |=> (out_pix == $past(bg_pix)));
endmodule

// File: tb/osd_compositor_bench.sv
// Directed bench for the overlay compositor.
module osd_compositor_bench;
    localparam int XW = 11;
    localparam int YW = 11;
    localparam int CW = 8;
    localparam int BW = 8;
    localparam int NW = 4;

    localparam logic [15:0] PX_V0 = 16'h5070;
    localparam logic [15:0] PX_V1 = 16'h9a30;
    localparam logic [15:0] PX_O0 = 16'hf010;
    localparam logic [15:0] PX_O1 = 16'h20e0;
    localparam logic [15:0] PX_BG = 16'h1080;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid = 1'b0;
    logic [XW-1:0] raster_x = '0;
    logic [YW-1:0] raster_y = '0;
    logic field_id = 1'b0;
    logic vsync = 1'b0;
    logic [NW-1:0] win_en = '0;
    logic [NW-1:0] win_field = '0;
    logic [NW*XW-1:0] win_x0 = '0;
    logic [NW*YW-1:0] win_y0 = '0;
    logic [NW*XW-1:0] win_w = '0;
    logic [NW*YW-1:0] win_h = '0;
    logic [NW*2-1:0] win_zoom_h = '0;
    logic [NW*2-1:0] win_zoom_v = '0;
    logic [5:0] ovl_level = '0;
    logic attr_mode = 1'b0;
    logic [BW-1:0] blink_reload = 8'd2;
    logic [15:0] bg_pix = PX_BG;
    logic [NW-1:0] req_hit;
    logic [NW*XW-1:0] req_x;
    logic [NW*YW-1:0] req_y;
    logic [NW*16-1:0] win_pix = {PX_O1, PX_O0, PX_V1, PX_V0};
    logic out_valid;
    logic [15:0] out_pix;

    int n_checks = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    osd_compositor #(.XW(XW), .YW(YW), .CW(CW), .BW(BW)) u_osd_compositor (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
        .raster_x(raster_x), .raster_y(raster_y), .field_id(field_id),
        .vsync(vsync), .win_en(win_en), .win_field(win_field),
        .win_x0(win_x0), .win_y0(win_y0), .win_w(win_w), .win_h(win_h),
        .win_zoom_h(win_zoom_h), .win_zoom_v(win_zoom_v),
        .ovl_level(ovl_level), .attr_mode(attr_mode),
        .blink_reload(blink_reload), .bg_pix(bg_pix),
        .req_hit(req_hit), .req_x(req_x), .req_y(req_y),
        .win_pix(win_pix), .out_valid(out_valid), .out_pix(out_pix)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mix(input logic [15:0] b, input logic [15:0] o,
                                        input int k);
        logic [15:0] r;
        for (int c = 0; c < 2; c++) begin
            int s;
            s = (int'(o[c*8 +: 8]) * k + int'(b[c*8 +: 8]) * (8 - k)) / 8;
            r[c*8 +: 8] = s[7:0];
        end
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pix_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_win(input int i, input int x0, input int y0, input int w,
                           input int h, input int zh, input int zv, input bit fld);
        win_en[i] = 1'b1;
        win_field[i] = fld;
        win_x0[i*XW +: XW] = XW'(x0);
        win_y0[i*YW +: YW] = YW'(y0);
        win_w[i*XW +: XW] = XW'(w);
        win_h[i*YW +: YW] = YW'(h);
        win_zoom_h[i*2 +: 2] = 2'(zh);
        win_zoom_v[i*2 +: 2] = 2'(zv);
    endtask

    task automatic clear_cfg();
        win_en = '0; win_field = '0; attr_mode = 1'b0; ovl_level = '0;
        win_pix = {PX_O1, PX_O0, PX_V1, PX_V0};
    endtask

    // Present a raster position; combinational requests settle 1 ns later.
    task automatic probe(input int x, input int y);
        @(negedge clk);
        raster_x = XW'(x);
        raster_y = YW'(y);
        pix_valid = 1'b1;
        #1;
    endtask

    // Present a position and return the registered output one clock later.
    task automatic show(input int x, input int y, output logic [15:0] px);
        probe(x, y);
        @(negedge clk);
        px = out_pix;
    endtask

    task automatic pulse_vsync();
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "out_valid in reset", 32'(out_valid), 0);
        chk("R1", "out_pix in reset", 32'(out_pix), 0);
        do_reset();
    endtask

    task automatic t_background();
        logic [15:0] px;
        clear_cfg();
        show(3, 3, px);
        chk("R6", "background with no window", 32'(px), 32'(PX_BG));
        chk("R2", "valid one cycle later", 32'(out_valid), 1);
        @(negedge clk);
        pix_valid = 1'b0;
        bg_pix = 16'h2222;
        @(negedge clk);
        chk("R2", "valid drops", 32'(out_valid), 0);
        chk("R2", "pixel holds when idle", 32'(out_pix), 32'(PX_BG));
        bg_pix = PX_BG;
    endtask

    task automatic t_hit();
        clear_cfg();
        set_win(0, 10, 20, 8, 4, 0, 0, 1'b0);
        probe(10, 20);
        chk("R3", "top-left corner hit", 32'(req_hit[0]), 1);
        chk("R4", "corner req_x", 32'(req_x[0 +: XW]), 0);
        probe(17, 23);
        chk("R3", "bottom-right hit", 32'(req_hit[0]), 1);
        chk("R4", "unzoomed req_y", 32'(req_y[0 +: YW]), 3);
        probe(18, 20);
        chk("R3", "right of width", 32'(req_hit[0]), 0);
        probe(9, 20);
        chk("R3", "left of start", 32'(req_hit[0]), 0);
        probe(12, 24);
        chk("R3", "below height", 32'(req_hit[0]), 0);
        win_en[0] = 1'b0;
        probe(12, 21);
        chk("R3", "disabled window misses", 32'(req_hit[0]), 0);
    endtask

    task automatic t_zoom();
        clear_cfg();
        set_win(0, 10, 20, 8, 4, 1, 2, 1'b0);
        probe(25, 35);
        chk("R4", "x2/x4 zoom hit", 32'(req_hit[0]), 1);
        chk("R4", "x2 req_x", 32'(req_x[0 +: XW]), 7);
        chk("R4", "x4 req_y", 32'(req_y[0 +: YW]), 3);
        probe(26, 35);
        chk("R4", "x2 width edge", 32'(req_hit[0]), 0);
        probe(25, 36);
        chk("R4", "x4 height edge", 32'(req_hit[0]), 0);
        set_win(0, 10, 20, 8, 4, 3, 0, 1'b0);
        probe(41, 20);
        chk("R4", "code 3 as x4 hit", 32'(req_hit[0]), 1);
        chk("R4", "code 3 req_x", 32'(req_x[0 +: XW]), 7);
        probe(42, 20);
        chk("R4", "code 3 width edge", 32'(req_hit[0]), 0);
    endtask

    task automatic t_field();
        clear_cfg();
        set_win(0, 10, 20, 8, 4, 0, 0, 1'b1);
        field_id = 1'b1;
        probe(12, 21);
        chk("R5", "odd line in odd field", 32'(req_hit[0]), 1);
        chk("R5", "field row 0", 32'(req_y[0 +: YW]), 0);
        probe(12, 27);
        chk("R5", "last field row", 32'(req_y[0 +: YW]), 3);
        chk("R5", "last field row hit", 32'(req_hit[0]), 1);
        probe(12, 29);
        chk("R5", "past field height", 32'(req_hit[0]), 0);
        probe(12, 22);
        chk("R5", "wrong parity", 32'(req_hit[0]), 0);
        field_id = 1'b0;
        probe(12, 22);
        chk("R5", "even field row 1", 32'(req_y[0 +: YW]), 1);
        field_id = 1'b0;
    endtask

    task automatic t_layers();
        logic [15:0] px;
        clear_cfg();
        set_win(0, 0, 0, 64, 64, 0, 0, 1'b0);
        show(5, 5, px);
        chk("R6", "video 0 over background", 32'(px), 32'(PX_V0));
        set_win(1, 0, 0, 64, 64, 0, 0, 1'b0);
        show(5, 5, px);
        chk("R6", "video 1 over video 0", 32'(px), 32'(PX_V1));
    endtask

    task automatic t_blend();
        logic [15:0] px;
        int lv [3] = '{0, 3, 7};
        clear_cfg();
        set_win(0, 0, 0, 64, 64, 0, 0, 1'b0);
        set_win(2, 0, 0, 64, 64, 0, 0, 1'b0);
        foreach (lv[j]) begin
            ovl_level[2:0] = 3'(lv[j]);
            show(5, 5, px);
            chk("R7", $sformatf("overlay 0 weight %0d", lv[j]), 32'(px),
                32'(mix(PX_V0, PX_O0, lv[j])));
        end
        win_pix[2*16 +: 16] = 16'h0000;
        ovl_level[2:0] = 3'd7;
        show(5, 5, px);
        chk("R8", "zero overlay pixel transparent", 32'(px), 32'(PX_V0));
        win_pix[2*16 +: 16] = PX_O0;
        set_win(3, 0, 0, 64, 64, 0, 0, 1'b0);
        ovl_level = {3'd3, 3'd5};
        show(5, 5, px);
        chk("R6", "overlay 1 over overlay 0", 32'(px),
            32'(mix(mix(PX_V0, PX_O0, 5), PX_O1, 3)));
    endtask

    task automatic t_attr();
        logic [15:0] px;
        clear_cfg();
        set_win(0, 0, 0, 64, 64, 0, 0, 1'b0);
        set_win(2, 0, 0, 64, 64, 0, 0, 1'b0);
        set_win(3, 0, 0, 32, 64, 0, 0, 1'b0);
        attr_mode = 1'b1;
        ovl_level = {3'd7, 3'd2};
        win_pix[3*16 +: 16] = 16'h0005;
        show(5, 5, px);
        chk("R9", "attribute weight replaces level", 32'(px),
            32'(mix(PX_V0, PX_O0, 5)));
        show(40, 5, px);
        chk("R9", "outside attribute uses own level", 32'(px),
            32'(mix(PX_V0, PX_O0, 2)));
    endtask

    task automatic t_blink();
        logic [15:0] px;
        clear_cfg();
        blink_reload = 8'd2;
        do_reset();
        set_win(0, 0, 0, 64, 64, 0, 0, 1'b0);
        set_win(2, 0, 0, 64, 64, 0, 0, 1'b0);
        set_win(3, 0, 0, 64, 64, 0, 0, 1'b0);
        attr_mode = 1'b1;
        win_pix[3*16 +: 16] = 16'h000d;
        show(5, 5, px);
        chk("R10", "visible after reset", 32'(px), 32'(mix(PX_V0, PX_O0, 5)));
        repeat (2) pulse_vsync();
        show(5, 5, px);
        chk("R10", "visible after two frames", 32'(px), 32'(mix(PX_V0, PX_O0, 5)));
        pulse_vsync();
        show(5, 5, px);
        chk("R10", "hidden after third frame", 32'(px), 32'(PX_V0));
        repeat (3) pulse_vsync();
        show(5, 5, px);
        chk("R10", "visible again after three more", 32'(px),
            32'(mix(PX_V0, PX_O0, 5)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_background();
        t_hit();
        t_zoom();
        t_field();
        t_layers();
        t_blend();
        t_attr();
        t_blink();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule